// File: doc/BRIEF.md
# Static Seven-Segment LCD Drive for a 3-1/2 Digit Reading

This block turns a 3-1/2 digit reading into the drive signals for a static liquid crystal display. The reading has three parts. The first is a BCD word for the units, tens and hundreds digits. The second is a single bit for the leading "1" of the thousands position. The third is a sign bit, and an overrange flag comes with it. The block makes a square-wave backplane from the system clock. Each segment output is that backplane, either unchanged or inverted. An unlit segment follows the backplane in phase. A lit segment is its complement. Because of this, the average voltage across any segment stays at zero while the display runs.

The segment on-states are captured only at a backplane transition, so a segment never changes partway through a half period. The displayed reading therefore updates cleanly no matter when the source changes it. A lamp-test input overrides everything: every segment output and the minus sign are forced to a steady high level, and the display shows -1888. The backplane divide ratio is a parameter. A ratio of 800 gives a backplane at one eight-hundredth of the clock.

Top module: `lcd_static_drv`

## Requirements
- R1: `bp` is 0 during reset and afterwards toggles every BP_DIV/2 clock cycles, so its full period is BP_DIV cycles.
- R2: Outside lamp test, an unlit segment output equals `bp` and a lit segment output equals the inverse of `bp`.
- R3: Each lower digit uses bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. The lit patterns for codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F in hex. Codes 10 to 15 light nothing.
- R4: `seg_one` is lit when `rd_thou` is 1 or when `rd_ovr` is 1, and unlit otherwise.
- R5: `seg_minus` is lit when `rd_neg` is 1 and unlit when it is 0.
- R6: While `rd_ovr` is 1, the units, tens and hundreds digits are all unlit, whatever `rd_bcd` holds.
- R7: While `lamp_test` is 1, every segment output, `seg_one` and `seg_minus` are held at a constant 1. This takes effect in the same cycle, and `bp` keeps toggling.
- R8: The inputs are captured on the clock edge at which `bp` toggles. A change made between toggles has no effect on any output until the next toggle.
- R9: During reset all segment outputs are 0, which means every segment is unlit and in phase with `bp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_thou | input | 1 | Thousands "1" present in the reading |
| rd_bcd | input | 12 | BCD digits: [11:8] hundreds, [7:4] tens, [3:0] units |
| rd_neg | input | 1 | Reading is negative |
| rd_ovr | input | 1 | Reading is out of range |
| lamp_test | input | 1 | Force all segments to a steady on level |
| bp | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units digit segments a..g |
| seg_tens | output | 7 | Tens digit segments a..g |
| seg_hund | output | 7 | Hundreds digit segments a..g |
| seg_one | output | 1 | Both segments of the thousands "1" |
| seg_minus | output | 1 | Minus sign segment |

## Verification
The assertions check on every cycle that the backplane moves only on the divider's load strobe, and that the held on-state changes only at that strobe and then takes the value decoded on the cycle before. They also check that every output inverts at a backplane edge when the on-state is unchanged, that the outputs stay frozen through lamp test, and that overrange blanks the lower digits and lights the "1". Only the bench scenarios can show the full font across all sixteen codes, the exact toggle spacing, and the sign and thousands mapping. The same holds for the deferral of mid-period input changes and the reset levels.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int SEG_W = 7;

  // Lit state of every segment; also the order of the drive bus.
  typedef struct packed {
    logic             minus;
    logic             one;
    logic [SEG_W-1:0] hund;
    logic [SEG_W-1:0] tens;
    logic [SEG_W-1:0] units;
  } seg_on_t;

  localparam int BUS_W = $bits(seg_on_t);

  // Conventional font, bit0 = a ... bit6 = g; non-decimal codes blank.
  function automatic logic [SEG_W-1:0] font7(input logic [3:0] code);
    logic [SEG_W-1:0] f;
    case (code)
      4'd0:    f = 7'h3F;
      4'd1:    f = 7'h06;
      4'd2:    f = 7'h5B;
      4'd3:    f = 7'h4F;
      4'd4:    f = 7'h66;
      4'd5:    f = 7'h6D;
      4'd6:    f = 7'h7D;
      4'd7:    f = 7'h07;
      4'd8:    f = 7'h7F;
      4'd9:    f = 7'h6F;
      default: f = 7'h00;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
module lcd_bp_gen #(
  parameter int HALF = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic bp,
  output logic load
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  assign load = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bp  <= 1'b0;
    end else if (load) begin
      cnt <= '0;
      bp  <= ~bp;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_bp_flips_on_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bp != $past(bp)));
  assert_bp_steady_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bp));

endmodule

// File: rtl/lcd_seg_decode.sv
module lcd_seg_decode
  import lcd_drv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_thou,
  input  logic [11:0]   rd_bcd,
  input  logic          rd_neg,
  input  logic          rd_ovr,
  output seg_on_t       nxt
);
  localparam int NDIG = 3;

  logic [NDIG-1:0][SEG_W-1:0] dig_on;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    assign dig_on[d] = rd_ovr ? '0 : font7(rd_bcd[4*d +: 4]);
  end

  always_comb begin
    nxt.units = dig_on[0];
    nxt.tens  = dig_on[1];
    nxt.hund  = dig_on[2];
    nxt.one   = rd_thou | rd_ovr;
    nxt.minus = rd_neg;
  end

  assert_ovr_blanks_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ovr |-> (nxt.units == '0 && nxt.tens == '0 && nxt.hund == '0 && nxt.one));

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_drv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bp,
  input  logic             lamp_test,
  input  seg_on_t          nxt,
  output seg_on_t          on_q,
  output logic [BUS_W-1:0] drive
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    on_q <= '0;
    else if (load) on_q <= nxt;
  end

  assign drive = lamp_test ? {BUS_W{1'b1}} : ({BUS_W{bp}} ^ on_q);

  assert_hold_between_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(on_q));
  assert_capture_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (on_q == $past(nxt)));

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int BP_DIV = 800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_thou,
  input  logic [11:0] rd_bcd,
  input  logic        rd_neg,
  input  logic        rd_ovr,
  input  logic        lamp_test,
  output logic        bp,
  output logic [6:0]  seg_units,
  output logic [6:0]  seg_tens,
  output logic [6:0]  seg_hund,
  output logic        seg_one,
  output logic        seg_minus
);
  localparam int HALF = BP_DIV / 2;

  logic             load;
  seg_on_t          nxt;
  seg_on_t          on_state;
  logic [BUS_W-1:0] drive;

  lcd_bp_gen #(.HALF(HALF)) u_bp (
    .clk(clk), .rst_n(rst_n), .bp(bp), .load(load)
  );

  lcd_seg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .rd_thou(rd_thou), .rd_bcd(rd_bcd),
    .rd_neg(rd_neg), .rd_ovr(rd_ovr), .nxt(nxt)
  );

  lcd_seg_drive u_drv (
    .clk(clk), .rst_n(rst_n), .load(load), .bp(bp), .lamp_test(lamp_test),
    .nxt(nxt), .on_q(on_state), .drive(drive)
  );

  assign {seg_minus, seg_one, seg_hund, seg_tens, seg_units} = drive;

  assert_invert_on_bp_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp_test && !$past(lamp_test) && (bp != $past(bp)) && $stable(on_state))
      |-> (drive == ~$past(drive)));
  assert_lamp_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test && $past(lamp_test)) |-> $stable(drive));

endmodule

// File: tb/test_lcd_static_drv.sv
module test_lcd_static_drv;
  localparam int CLK_PERIOD = 10;
  localparam int BP_DIV     = 8;
  localparam int HALF       = BP_DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_thou = 1'b0;
  logic [11:0] rd_bcd = '0;
  logic        rd_neg = 1'b0;
  logic        rd_ovr = 1'b0;
  logic        lamp_test = 1'b0;
  logic        bp;
  logic [6:0]  seg_units, seg_tens, seg_hund;
  logic        seg_one, seg_minus;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_static_drv #(.BP_DIV(BP_DIV)) i_lcd_static_drv (
    .clk(clk), .rst_n(rst_n), .rd_thou(rd_thou), .rd_bcd(rd_bcd),
    .rd_neg(rd_neg), .rd_ovr(rd_ovr), .lamp_test(lamp_test), .bp(bp),
    .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
    .seg_one(seg_one), .seg_minus(seg_minus)
  );

  // Lit segments per code, listed segment by segment (a..g).
  function automatic logic [6:0] ref_font(input int code);
    logic a, b, c, d, e, f, g;
    if (code > 9) return 7'h00;
    a = !(code == 1 || code == 4);
    b = !(code == 5 || code == 6);
    c = (code != 2);
    d = !(code == 1 || code == 4 || code == 7);
    e = (code == 0 || code == 2 || code == 6 || code == 8);
    f = !(code == 1 || code == 2 || code == 3 || code == 7);
    g = !(code == 0 || code == 1 || code == 7);
    return {g, f, e, d, c, b, a};
  endfunction

  function automatic logic [22:0] ref_on(input logic thou, input logic [11:0] bcd,
                                         input logic neg, input logic ovr);
    logic [6:0] u, t, h;
    u = ovr ? 7'h0 : ref_font(int'(bcd[3:0]));
    t = ovr ? 7'h0 : ref_font(int'(bcd[7:4]));
    h = ovr ? 7'h0 : ref_font(int'(bcd[11:8]));
    return {neg, thou | ovr, h, t, u};
  endfunction

  function automatic logic [22:0] outs();
    return {seg_minus, seg_one, seg_hund, seg_tens, seg_units};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_toggle();
    logic b0;
    b0 = bp;
    while (bp == b0) @(negedge clk);
  endtask

  // Drive a reading, let it load, then check both backplane phases.
  task automatic show(input logic thou, input logic [11:0] bcd, input logic neg,
                      input logic ovr, input string req);
    logic [22:0] on;
    @(negedge clk);
    rd_thou = thou; rd_bcd = bcd; rd_neg = neg; rd_ovr = ovr;
    on = ref_on(thou, bcd, neg, ovr);
    wait_toggle();
    check(outs() == (on ^ {23{bp}}), req, 32'(outs()), 32'(on ^ {23{bp}}));
    wait_toggle();
    check(outs() == (on ^ {23{bp}}), req, 32'(outs()), 32'(on ^ {23{bp}}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset levels
    repeat (3) @(negedge clk);
    check(bp == 1'b0, "R9 bp", 32'(bp), 0);
    check(outs() == '0, "R9 segs", 32'(outs()), 0);
    rst_n = 1'b1;

    // R1: toggle spacing
    wait_toggle();
    for (int k = 0; k < 3; k++) begin
      logic b0;
      int n;
      b0 = bp; n = 0;
      while (bp == b0) begin @(negedge clk); n++; end
      check(n == HALF, "R1 half period", 32'(n), 32'(HALF));
    end

    // R3, R2, R4, R5: sweep of all codes in every digit position
    for (int v = 0; v < 16; v++) begin
      logic [11:0] bcd;
      bcd = {4'((v + 7) % 16), 4'((v + 3) % 16), 4'(v)};
      show(v[0], bcd, v[1], 1'b0, "R3 font sweep");
    end
    show(1'b1, 12'h999, 1'b0, 1'b0, "R4 thousands on");
    show(1'b0, 12'h000, 1'b1, 1'b0, "R5 minus zero");
    show(1'b0, 12'h000, 1'b0, 1'b0, "R2 all off in phase");

    // R6: overrange blanks low digits, lights the one
    show(1'b0, 12'h888, 1'b0, 1'b1, "R6 overrange");
    show(1'b0, 12'h123, 1'b1, 1'b1, "R6 overrange negative");

    // R8: mid-period change deferred
    show(1'b0, 12'h456, 1'b0, 1'b0, "R8 base");
    begin
      logic [22:0] old_on, new_on;
      old_on = ref_on(1'b0, 12'h456, 1'b0, 1'b0);
      new_on = ref_on(1'b1, 12'h789, 1'b1, 1'b0);
      rd_thou = 1'b1; rd_bcd = 12'h789; rd_neg = 1'b1;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        check(outs() == (old_on ^ {23{bp}}), "R8 held mid-period",
              32'(outs()), 32'(old_on ^ {23{bp}}));
      end
      wait_toggle();
      check(outs() == (new_on ^ {23{bp}}), "R8 taken at edge",
            32'(outs()), 32'(new_on ^ {23{bp}}));
    end

    // R7: lamp test steady all-on, bp keeps running
    @(negedge clk);
    rd_thou = 1'b0; rd_bcd = 12'h000; rd_neg = 1'b0; rd_ovr = 1'b0;
    lamp_test = 1'b1;
    #1;
    check(outs() == '1, "R7 immediate", 32'(outs()), 32'h7FFFFF);
    begin
      int toggles;
      logic bl;
      toggles = 0; bl = bp;
      for (int k = 0; k < 3 * HALF; k++) begin
        @(negedge clk);
        if (bp != bl) toggles++;
        bl = bp;
        check(outs() == '1, "R7 steady", 32'(outs()), 32'h7FFFFF);
      end
      check(toggles >= 2, "R7 bp running", 32'(toggles), 2);
    end
    @(negedge clk);
    lamp_test = 1'b0;
    show(1'b0, 12'h000, 1'b0, 1'b0, "R7 release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule